// File: doc/BRIEF.md
# Sector Error Count Aggregator

After a multi-sector decode, the error-correction engine leaves one small count per sector, packed several to a word in a local register array. This block walks those counts after a start pulse and reduces them to three figures that firmware or a controller uses to judge the page. The first is the sum of bits corrected over all correctable sectors. The second is how many sectors could not be corrected. The third is the largest count seen in any one correctable sector, which is the worst bit-flip level of the page.

A count field holding all ones does not mean a large count. It marks a sector the decoder gave up on. That sector adds one to the failure figure and is kept out of both the sum and the maximum. The array is filled through a simple word write port. A scan then takes one sector per clock, and a one-cycle done pulse closes it. The field width, the lane spacing, the lanes per word and the sector capacity are all parameters.

Top module: `sector_err_agg`

## Requirements
- R1: Sector i is read from word i/LANES, lane i mod LANES. Its count occupies bits [(i mod LANES)*LANE_PITCH +: FIELD_W] of that word. With the defaults (4 lanes, pitch 8, width 6), the two bits above each field are ignored.
- R2: A count field whose FIELD_W bits are all ones (63 by default) marks an uncorrectable sector. Each such sector adds one to `fail_total`.
- R3: `corrected_total` is the sum of the counts of all correctable scanned sectors. Marker values are never added.
- R4: `max_flips` is the largest count among the correctable scanned sectors, or 0 when there are none. It never holds the marker value.
- R5: A start accepted with N > 0 sectors raises `done` for exactly one cycle, N+1 clock edges after the edge that accepted the start. When `done` is high the totals are final, and they hold until the next accepted start.
- R6: A start with a sector count of 0 raises `done` on the edge after the accepting edge, with all three totals at 0.
- R7: The edge that accepts a start clears all three totals to 0.
- R8: A start that arrives while a scan is running, or in the cycle before `done`, is ignored. It does not restart the scan, does not clear the totals and does not cause an extra `done`.
- R9: A sector count above MAX_SECTORS (32 by default) is treated as MAX_SECTORS.
- R10: Synchronous reset zeroes the totals, lowers `done` and clears every word of the count array.
- R11: Sectors at or beyond the requested count are not scanned, whatever their array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a scan when the block is idle |
| sector_count | input | 6 | Number of sectors to scan; values above 32 are clamped |
| wr_en | input | 1 | Writes `wr_data` into the count array |
| wr_addr | input | 3 | Word index in the count array |
| wr_data | input | 32 | Packed count word |
| corrected_total | output | 11 | Sum of correctable sector counts |
| fail_total | output | 6 | Number of uncorrectable sectors |
| max_flips | output | 6 | Largest correctable sector count |
| done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The bench sweeps every sector count from 0 to 33, plus 40 and 63, over six count patterns. The patterns include all-marker, all-62 (one below the marker) and mixes where markers fall in different lanes. Writing junk into the bits between lanes exposes a lane that is sliced too wide. Treating 62 or 63 the wrong way shows up as a wrong sum, a wrong failure count or a maximum of 63. A scan that runs one sector long or short gives wrong totals on nearly every count, and a misplaced done is caught cycle by cycle. Holding start high through a whole scan would make a design without the busy guard clear its totals or pulse done twice. A count of 40 would make a design without the clamp wrap or read past the array.

// File: rtl/sea_pkg.sv
package sea_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W_MAX = 8;

    typedef enum logic [1:0] {
        SEA_IDLE,
        SEA_SCAN,
        SEA_FINISH
    } sea_state_e;

    // One extracted sector: marker flag plus the raw count (zero-extended)
    typedef struct packed {
        logic                 bad;
        logic [CNT_W_MAX-1:0] count;
    } sea_sample_t;

    // Width needed for the corrected-bit sum: every sector at the largest
    // correctable value (all ones minus one)
    function automatic int sum_width(input int sectors, input int field_w);
        return $clog2(sectors * ((1 << field_w) - 2) + 1);
    endfunction

endpackage

// File: rtl/sea_count_store.sv
module sea_count_store #(
    parameter int WORDS  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [sea_pkg::WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [sea_pkg::WORD_W-1:0] rd_data
);

    logic [sea_pkg::WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sea_lane_pick.sv
module sea_lane_pick #(
    parameter int LANES      = 4,
    parameter int FIELD_W    = 6,
    parameter int LANE_PITCH = 8,
    parameter int LSEL_W     = 2
) (
    input  logic [sea_pkg::WORD_W-1:0] word,
    input  logic [LSEL_W-1:0]          lane,
    output sea_pkg::sea_sample_t       sample
);

    logic [FIELD_W-1:0] fields [LANES];
    logic [FIELD_W-1:0] picked;
    logic               unused_word;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign fields[l] = word[l*LANE_PITCH +: FIELD_W];
    end

    assign picked       = fields[lane];
    assign sample.bad   = &picked;
    assign sample.count = sea_pkg::CNT_W_MAX'(picked);
    assign unused_word  = ^word;

endmodule

// File: rtl/sea_accum.sv
module sea_accum #(
    parameter int FIELD_W = 6,
    parameter int SUM_W   = 11,
    parameter int FAIL_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  sea_pkg::sea_sample_t sample,
    output logic [SUM_W-1:0]     sum,
    output logic [FAIL_W-1:0]    fails,
    output logic [FIELD_W-1:0]   worst
);

    logic [FIELD_W-1:0] cnt;
    logic               unused_hi;

    assign cnt       = sample.count[FIELD_W-1:0];
    assign unused_hi = ^sample.count;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum   <= '0;
            fails <= '0;
            worst <= '0;
        end else if (en) begin
            if (sample.bad) begin
                fails <= fails + FAIL_W'(1);
            end else begin
                sum <= sum + SUM_W'(cnt);
                if (cnt > worst) begin
                    worst <= cnt;
                end
            end
        end
    end

endmodule

// File: rtl/sector_err_agg.sv
module sector_err_agg #(
    parameter int FIELD_W      = 6,
    parameter int LANE_PITCH   = 8,
    parameter int LANES        = 4,
    parameter int MAX_SECTORS  = 32,
    localparam int WORDS   = MAX_SECTORS / LANES,
    localparam int WADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LSEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int IDX_W   = $clog2(MAX_SECTORS),
    localparam int N_W     = $clog2(MAX_SECTORS + 1),
    localparam int SUM_W   = sea_pkg::sum_width(MAX_SECTORS, FIELD_W),
    localparam int FAIL_W  = N_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [N_W-1:0]             sector_count,
    input  logic                       wr_en,
    input  logic [WADDR_W-1:0]         wr_addr,
    input  logic [sea_pkg::WORD_W-1:0] wr_data,
    output logic [SUM_W-1:0]           corrected_total,
    output logic [FAIL_W-1:0]          fail_total,
    output logic [FIELD_W-1:0]         max_flips,
    output logic                       done
);

    import sea_pkg::*;

    sea_state_e                state;
    logic [IDX_W-1:0]          idx;
    logic [IDX_W-1:0]          last;
    logic                      busy;
    logic                      accept;
    logic [N_W-1:0]            n_clamped;
    logic [N_W-1:0]            n_minus;
    logic                      unused_nm;
    logic [WORD_W-1:0]         rd_word;
    logic [WADDR_W-1:0]        rd_addr;
    logic [LSEL_W-1:0]         lane;
    sea_sample_t               sample;

    assign busy      = (state != SEA_IDLE);
    assign accept    = start && !busy;
    assign n_clamped = (sector_count > N_W'(MAX_SECTORS)) ? N_W'(MAX_SECTORS) : sector_count;
    assign n_minus   = n_clamped - N_W'(1);
    assign unused_nm = ^n_minus;

    if (LANES > 1) begin : g_multi_lane
        assign rd_addr = WADDR_W'(idx >> LSEL_W);
        assign lane    = idx[LSEL_W-1:0];
    end else begin : g_single_lane
        assign rd_addr = WADDR_W'(idx);
        assign lane    = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEA_IDLE;
            idx   <= '0;
            last  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SEA_IDLE: begin
                    if (accept) begin
                        idx   <= '0;
                        last  <= n_minus[IDX_W-1:0];
                        state <= (n_clamped == '0) ? SEA_FINISH : SEA_SCAN;
                    end
                end
                SEA_SCAN: begin
                    idx <= idx + IDX_W'(1);
                    if (idx == last) begin
                        state <= SEA_FINISH;
                    end
                end
                SEA_FINISH: begin
                    done  <= 1'b1;
                    state <= SEA_IDLE;
                end
                default: state <= SEA_IDLE;
            endcase
        end
    end

    sea_count_store #(
        .WORDS  (WORDS),
        .ADDR_W (WADDR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    sea_lane_pick #(
        .LANES      (LANES),
        .FIELD_W    (FIELD_W),
        .LANE_PITCH (LANE_PITCH),
        .LSEL_W     (LSEL_W)
    ) u_pick (
        .word   (rd_word),
        .lane   (lane),
        .sample (sample)
    );

    sea_accum #(
        .FIELD_W (FIELD_W),
        .SUM_W   (SUM_W),
        .FAIL_W  (FAIL_W)
    ) u_accum (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .en     (state == SEA_SCAN),
        .sample (sample),
        .sum    (corrected_total),
        .fails  (fail_total),
        .worst  (max_flips)
    );

endmodule

// File: rtl/sector_err_agg_chk.sv
module sector_err_agg_chk #(
    parameter int FIELD_W     = 6,
    parameter int MAX_SECTORS = 32,
    parameter int N_W         = 6,
    parameter int SUM_W       = 11,
    parameter int FAIL_W      = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [N_W-1:0]     sector_count,
    input logic               busy,
    input logic               done,
    input logic [SUM_W-1:0]   corrected_total,
    input logic [FAIL_W-1:0]  fail_total,
    input logic [FIELD_W-1:0] max_flips
);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_scan_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(corrected_total) && $stable(fail_total) && $stable(max_flips)));

    assert_empty_scan_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && sector_count == '0) |=> ##1 done);

    assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (corrected_total == '0 && fail_total == '0 && max_flips == '0));

    assert_sum_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (corrected_total >= $past(corrected_total) && fail_total >= $past(fail_total)));

    assert_fail_bound_R2: assert property (@(posedge clk) disable iff (rst)
        fail_total <= FAIL_W'(MAX_SECTORS));

    assert_max_not_marker_R4: assert property (@(posedge clk) disable iff (rst)
        !(&max_flips));

endmodule

bind sector_err_agg sector_err_agg_chk #(
    .FIELD_W     (FIELD_W),
    .MAX_SECTORS (MAX_SECTORS),
    .N_W         (N_W),
    .SUM_W       (SUM_W),
    .FAIL_W      (FAIL_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .sector_count    (sector_count),
    .busy            (busy),
    .done            (done),
    .corrected_total (corrected_total),
    .fail_total      (fail_total),
    .max_flips       (max_flips)
);

// File: tb/sector_err_agg_tb.sv
module sector_err_agg_tb;

    localparam int NSEC   = 32;
    localparam int NWORD  = 8;
    localparam int MARKER = 63;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  sector_count = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [10:0] corrected_total;
    logic [5:0]  fail_total;
    logic [5:0]  max_flips;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int counts [NSEC];

    always #5 clk = ~clk;

    sector_err_agg u_dut (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .sector_count    (sector_count),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .corrected_total (corrected_total),
        .fail_total      (fail_total),
        .max_flips       (max_flips),
        .done            (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pattern(input int p, input int i);
        case (p)
            0:       return 0;
            1:       return MARKER;
            2:       return 62;
            3:       return i;
            4:       return (i * 11 + 8) % 64;
            default: return (i % 3 == 0) ? MARKER : (i * 5) % 63;
        endcase
    endfunction

    // R1: pack four 6-bit fields at 8-bit spacing, junk in the two bits above each
    task automatic load_counts(input int p);
        for (int w = 0; w < NWORD; w++) begin
            logic [31:0] word;
            word = '0;
            for (int l = 0; l < 4; l++) begin
                word[l*8 +: 6]     = 6'(counts[w*4+l]);
                word[l*8 + 6 +: 2] = 2'((w + l + p) % 4);
            end
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 3'(w);
            wr_data = word;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_scan(input int n, input bit poke);
        int nn;
        int e_sum;
        int e_fail;
        int e_max;
        bit timing_ok;
        string tag;
        nn = (n > NSEC) ? NSEC : n;
        e_sum = 0;
        e_fail = 0;
        e_max = 0;
        for (int i = 0; i < nn; i++) begin
            if (counts[i] == MARKER) begin
                e_fail++;
            end else begin
                e_sum += counts[i];
                if (counts[i] > e_max) e_max = counts[i];
            end
        end
        tag = (n > NSEC) ? "R9" : ((n < NSEC) ? "R11" : "R1");

        @(negedge clk);
        start = 1'b1;
        sector_count = 6'(n);
        @(posedge clk);
        #1;
        start = poke;
        check(corrected_total == 0 && fail_total == 0 && max_flips == 0, "R7 cleared at start",
              int'(corrected_total) + int'(fail_total) + int'(max_flips), 0);
        timing_ok = 1'b1;
        for (int c = 1; c <= nn + 1; c++) begin
            @(posedge clk);
            #1;
            if (done !== (c == nn + 1)) timing_ok = 1'b0;
            if (c == nn + 1) start = 1'b0;
        end
        check(timing_ok, (nn == 0) ? "R6 done timing" : "R5 done timing", n, nn + 1);
        check(int'(corrected_total) == e_sum, {"R3 sum ", tag}, int'(corrected_total), e_sum);
        check(int'(fail_total) == e_fail, {"R2 fails ", tag}, int'(fail_total), e_fail);
        check(int'(max_flips) == e_max, {"R4 max ", tag}, int'(max_flips), e_max);
        @(posedge clk);
        #1;
        check(!done && int'(corrected_total) == e_sum && int'(fail_total) == e_fail,
              poke ? "R8 start during scan ignored" : "R5 single done and hold",
              int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(corrected_total == 0 && fail_total == 0 && max_flips == 0 && !done,
              "R10 reset outputs", int'(corrected_total) + int'(done), 0);
        for (int i = 0; i < NSEC; i++) counts[i] = 0;
        run_scan(NSEC, 1'b0);  // R10: array cleared by reset gives zero totals
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < NSEC; i++) counts[i] = pattern(p, i);
            load_counts(p);
            for (int n = 0; n <= 33; n++) begin
                run_scan(n, (n % 5) == 3);
            end
            run_scan(40, 1'b0);
            run_scan(63, 1'b1);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule